// File: doc/BRIEF.md
# Terminal-Count Interrupt Timer Channel

This block is a single timer channel that counts down from a programmed value and raises its output when the count runs out. Software first writes a setup word, which drops the output and stops the channel. It then loads a 16-bit start value. After a one-tick startup, the channel subtracts one on every counting tick while the gate input is high. When the count arrives at zero, the output rises and becomes the interrupt request. It holds high until the channel is set up again or given a new value.

The counter steps either as a 16-bit binary number or as four decimal digits with digit borrow. The counting tick is a clock enable on the system clock. The live count is always visible on `count_o`.

`load_stb`/`load_val` form a single-beat input that is always accepted: the channel has no ready signal, so there is no back-pressure, and a load takes effect on the edge where `load_stb` is high. All other pins are plain control and status signals.

Top module: `cdch_top`

## Requirements
- R1: A cycle with `cw_wr` high and `load_stb` low drives `out_o` low at the next clock edge, leaves `count_o` unchanged, and stops decrementing until a value is loaded.
- R2: A cycle with `load_stb` high sets `count_o` to `load_val` and `out_o` low at the next edge. This holds even if `cw_wr` or a counting tick occurs in the same cycle (load has priority), and it applies while counting is in progress.
- R3: The first cycle with `cnt_en` high after a load is a startup tick that does not change the count. Each later cycle with `cnt_en` and `gate` both high lowers the count by exactly one.
- R4: A cycle with `cnt_en` high and `gate` low leaves the count unchanged once the channel is running. The startup tick is consumed whatever the level of `gate`.
- R5: With `bcd_mode` = 0, a decrement of 0x0000 gives 0xFFFF.
- R6: With `bcd_mode` = 1, the count is four BCD digits, with bits [3:0] the least significant digit. A decrement borrows between digits, so 0x1000 becomes 0x0999 and 0x0000 becomes 0x9999. `bcd_mode` is sampled on every decrement.
- R7: `out_o` rises on the same edge on which a decrement makes the count zero. It then stays high, through the wrap past zero and beyond, until a load or a setup write.
- R8: After reset, `count_o` is 0 and `out_o` is 0. Without a load, the count never decrements after reset or after a setup write.
- R9: A cycle with `cnt_en` low and `load_stb` low leaves `count_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting tick (clock enable) |
| cw_wr | input | 1 | Setup word written to this channel (one-cycle pulse) |
| load_stb | input | 1 | Start value valid (one-cycle pulse, always accepted) |
| load_val | input | 16 | Start value |
| bcd_mode | input | 1 | 1 = four-digit decimal decrement, 0 = binary decrement |
| gate | input | 1 | Counting enable level |
| out_o | output | 1 | Terminal-count output |
| count_o | output | 16 | Live count |

## Verification
Each result is due on the first clock edge after the cycle that carries its stimulus: the load value, the falling output, a single decrement, and the rising output together with the zero count. This is because the count and the output are each one register deep. The bench drives every input at the falling edge and advances a reference model by one step per driven cycle. It compares both outputs 1 ns after the following rising edge, so every comparison is made exactly one register delay after the stimulus it depends on. The startup tick appears in the model as its own state, so a count that moves one cycle too early or too late shows up as a mismatch.

// File: rtl/cdch_pkg.sv
package cdch_pkg;
  // Channel phase: idle (no value), armed (waiting startup tick), running.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_RUN   = 2'd2
  } ch_phase_e;
endpackage

// File: rtl/cdch_decr.sv
// Combinational one-step decrement, binary or packed decimal digits.
// CNT_W must be a multiple of 4.
module cdch_decr #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             bcd,
  output logic [CNT_W-1:0] nxt,
  output logic             nxt_zero
);
  localparam int NDIG = CNT_W / 4;

  logic [CNT_W-1:0] bin_nxt;
  logic [CNT_W-1:0] dec_nxt;
  logic [NDIG-1:0]  brw;

  assign bin_nxt = cur - {{(CNT_W-1){1'b0}}, 1'b1};
  assign brw[0]  = 1'b1;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    logic [3:0] dig;
    assign dig = cur[g*4 +: 4];
    assign dec_nxt[g*4 +: 4] = brw[g] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
    if (g < NDIG - 1) begin : g_chain
      assign brw[g+1] = brw[g] & (dig == 4'd0);
    end
  end

  assign nxt      = bcd ? dec_nxt : bin_nxt;
  assign nxt_zero = (nxt == '0);
endmodule

// File: rtl/cdch_seq.sv
// Phase control and count register.
module cdch_seq
  import cdch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cw_wr,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             bcd_mode,
  input  logic             gate,
  output logic [CNT_W-1:0] count_q,
  output logic             hit_zero
);
  ch_phase_e        phase_q;
  logic [CNT_W-1:0] dec_val;
  logic             dec_zero;
  logic             dec_fire;

  cdch_decr #(.CNT_W(CNT_W)) u_decr (
    .cur      (count_q),
    .bcd      (bcd_mode),
    .nxt      (dec_val),
    .nxt_zero (dec_zero)
  );

  assign dec_fire = (phase_q == PH_RUN) && cnt_en && gate && !load_stb && !cw_wr;
  assign hit_zero = dec_fire && dec_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      count_q <= '0;
    end else if (load_stb) begin
      phase_q <= PH_ARMED;
      count_q <= load_val;
    end else if (cw_wr) begin
      phase_q <= PH_IDLE;
    end else if (cnt_en) begin
      if (phase_q == PH_ARMED) phase_q <= PH_RUN;
      if (dec_fire) count_q <= dec_val;
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> count_q == $past(load_val)); // R2
  AST_ARMED_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ARMED && !load_stb) |=> $stable(count_q)); // R3
  AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && cnt_en && gate && !bcd_mode && !load_stb && !cw_wr)
      |=> count_q == $past(count_q) - 1'b1); // R3
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !gate && !load_stb) |=> $stable(count_q)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !load_stb) |=> $stable(count_q)); // R8
  AST_EN_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_stb) |=> $stable(count_q)); // R9
endmodule

// File: rtl/cdch_out.sv
// Terminal-count output flop.
module cdch_out (
  input  logic clk,
  input  logic rst_n,
  input  logic cw_wr,
  input  logic load_stb,
  input  logic hit_zero,
  output logic out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  out_q <= 1'b0;
    else if (load_stb || cw_wr)  out_q <= 1'b0;
    else if (hit_zero)           out_q <= 1'b1;
  end

  AST_CW_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cw_wr |=> !out_q); // R1
  AST_LOAD_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !out_q); // R2
  AST_OUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && !load_stb && !cw_wr) |=> out_q); // R7
  AST_OUT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(hit_zero)); // R7
endmodule

// File: rtl/cdch_top.sv
module cdch_top #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cw_wr,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic             bcd_mode,
  input  logic             gate,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  logic hit_zero;

  cdch_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .cw_wr    (cw_wr),
    .load_stb (load_stb),
    .load_val (load_val),
    .bcd_mode (bcd_mode),
    .gate     (gate),
    .count_q  (count_o),
    .hit_zero (hit_zero)
  );

  cdch_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .cw_wr    (cw_wr),
    .load_stb (load_stb),
    .hit_zero (hit_zero),
    .out_q    (out_o)
  );

  AST_ZERO_WITH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_o) |-> count_o == '0); // R7
endmodule

// File: tb/cdch_top_tb_top.sv
`timescale 1ns/1ps
module cdch_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, cw_wr = 1'b0, load_stb = 1'b0, bcd_mode = 1'b0, gate = 1'b0;
  logic [15:0] load_val = '0;
  logic        out_o;
  logic [15:0] count_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state: 0 idle, 1 armed, 2 running
  int          m_ph = 0;
  logic [15:0] m_cnt = '0;
  logic        m_out = 1'b0;

  always #10 clk = ~clk;

  cdch_top dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cw_wr(cw_wr),
    .load_stb(load_stb), .load_val(load_val), .bcd_mode(bcd_mode),
    .gate(gate), .out_o(out_o), .count_o(count_o)
  );

  function automatic logic [15:0] ref_dec(input logic [15:0] v, input logic b);
    int n;
    if (!b) return v - 16'd1;
    n = v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
    n = (n + 9999) % 10000;
    return {4'(n/1000), 4'((n/100)%10), 4'((n/10)%10), 4'(n%10)};
  endfunction

  function automatic logic [15:0] to_bcd(input int n);
    return {4'(n/1000), 4'((n/100)%10), 4'((n/10)%10), 4'(n%10)};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic ld, input logic [15:0] v, input logic cw,
                      input logic en, input logic g, input logic b, input string req);
    logic [15:0] n;
    @(negedge clk);
    load_stb = ld; load_val = v; cw_wr = cw; cnt_en = en; gate = g; bcd_mode = b;
    if (ld) begin
      m_cnt = v; m_out = 1'b0; m_ph = 1;
    end else if (cw) begin
      m_out = 1'b0; m_ph = 0;
    end else if (en) begin
      if (m_ph == 1) m_ph = 2;
      else if (m_ph == 2 && g) begin
        n = ref_dec(m_cnt, b);
        if (n == 16'd0) m_out = 1'b1;
        m_cnt = n;
      end
    end
    @(posedge clk);
    #1;
    chk(req, count_o, m_cnt, "count");
    chk(req, {15'd0, out_o}, {15'd0, m_out}, "out");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #35 rst_n = 1'b1;
    #1;
    chk("R8", count_o, 16'h0000, "reset count");
    chk("R8", {15'd0, out_o}, 16'd0, "reset out");

    // R8: no decrement without a load
    for (int i = 0; i < 4; i++) step(0, 16'h0, 0, 1, 1, 0, "R8");
    step(0, 16'h0, 1, 1, 1, 0, "R1");

    // R3 / R7 binary countdown from 3, wrap (R5)
    step(1, 16'd3, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 1, 1, 0, "R3");          // startup tick
    chk("R3", count_o, 16'd3, "startup keeps count");
    step(0, 0, 0, 1, 1, 0, "R3");
    step(0, 0, 0, 1, 1, 0, "R3");
    step(0, 0, 0, 1, 1, 0, "R7");
    chk("R7", {15'd0, out_o}, 16'd1, "out high at zero");
    step(0, 0, 0, 1, 1, 0, "R5");
    chk("R5", count_o, 16'hFFFF, "binary wrap");
    chk("R7", {15'd0, out_o}, 16'd1, "out stays high after wrap");
    // R9: enable low holds
    step(0, 0, 0, 0, 1, 0, "R9");
    // R4: gate low holds
    step(0, 0, 0, 1, 0, 0, "R4");
    step(0, 0, 0, 1, 0, 0, "R4");
    // R1: setup write drops out, halts
    step(0, 0, 1, 0, 1, 0, "R1");
    step(0, 0, 0, 1, 1, 0, "R1");

    // R6: BCD borrow
    step(1, 16'h1000, 0, 0, 1, 1, "R2");
    step(0, 0, 0, 1, 0, 1, "R4");           // startup consumed with gate low
    step(0, 0, 0, 1, 1, 1, "R6");
    chk("R6", count_o, 16'h0999, "bcd borrow");
    step(1, 16'h0001, 0, 0, 1, 1, "R2");
    step(0, 0, 0, 1, 1, 1, "R3");
    step(0, 0, 0, 1, 1, 1, "R7");
    step(0, 0, 0, 1, 1, 1, "R6");
    chk("R6", count_o, 16'h9999, "bcd wrap");

    // R2: reload mid-count, and load beats setup write
    step(0, 0, 0, 1, 1, 0, "R7");
    step(1, 16'd50, 1, 1, 1, 0, "R2");
    chk("R2", count_o, 16'd50, "load wins over setup write");
    step(0, 0, 0, 1, 1, 0, "R3");
    step(0, 0, 0, 1, 1, 0, "R3");
    step(1, 16'd2, 0, 1, 1, 0, "R2");
    step(0, 0, 0, 1, 1, 0, "R3");
    step(0, 0, 0, 1, 1, 0, "R3");
    step(0, 0, 0, 1, 1, 0, "R7");

    // random phase
    begin
      logic b;
      b = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        int r;
        r = int'($urandom % 100);
        if (r < 4 || i == 0) begin
          b = 1'($urandom);
          step(1, b ? to_bcd(int'($urandom % 30)) : 16'($urandom % 30),
               0, 1'($urandom), 1'($urandom), b, "R2");
        end else if (r < 6) begin
          step(0, 0, 1, 1'($urandom), 1, b, "R1");
        end else begin
          step(0, 0, 0, ($urandom % 4) != 0, ($urandom % 5) != 0, b, "R3/R7");
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule